// File: doc/BRIEF.md
# Per-Processor Interrupt Presentation Unit

This unit is the part of an interrupt controller that faces a single processor. Upstream routing logic hands it delivery requests, each naming a source index together with that source's priority and vector. The unit keeps two sets with one bit per source. The raised set holds sources that are waiting to be taken. The in-service set holds sources the processor has taken but not yet retired. A task-priority register filters out requests that are not urgent enough. The unit drives one interrupt line toward the processor.

The processor works through a small register window. Reading the acknowledge register picks the most urgent raised source and checks it again against its activity input and the current task priority. If the check passes, the source moves into service and its vector is returned. If it fails, the spurious vector is returned. Writing the end-of-interrupt register retires the most urgent in-service source, and the line may then be raised again. When a source's activity flag should be cleared, the unit emits a one-cycle pulse naming that source. The flag itself lives in the source configuration logic, outside this block.

Register map (addr): 0 task priority (read/write), 1 spurious vector (read/write), 2 identity (read-only), 3 acknowledge (read, with side effects), 4 end-of-interrupt (write). Reads return data combinationally in the cycle that `rd_en` is high, and side effects take place at that clock edge. An unmapped address reads as zero.

Top module: `irq_presenter`

## Requirements
- R1: The task priority is 4 bits and resets to 15. A write to addr 0 keeps only wdata[3:0], and a read of addr 0 returns it zero-extended.
- R2: A request is accepted into the raised set only when its priority is strictly greater than the task priority at that clock edge.
- R3: A request for a source that is already in the raised set is dropped. The priority and vector stored earlier for that source are kept.
- R4: The most urgent member of a set is the one with the highest priority. When priorities are equal, the lowest source index wins.
- R5: irq_o goes high one cycle after an accepted request whose priority exceeds the best raised priority held before it. An empty raised set counts as priority -1.
- R6: The spurious vector is 8 bits, resets to 0xFF and is written through addr 1. An acknowledge read with an empty raised set returns it and changes nothing.
- R7: On an acknowledge read, if the selected source's src_active bit is low, or its priority is no longer above the task priority, the read returns the spurious vector and pulses clr_valid for that source. Otherwise the source enters the in-service set and its vector is returned.
- R8: After any acknowledge read of a non-empty raised set, the selected source leaves the raised set. If its src_level bit is 0 (edge-sensitive), clr_valid also pulses in that cycle with clr_src set to its index.
- R9: An end-of-interrupt write removes the most urgent in-service source. irq_o is then set if the best raised priority exceeds the best remaining in-service priority, with -1 standing for an empty set.
- R10: Addr 2 reads as CPU_ID and addr 4 reads as zero. Writes to addr 2 and addr 3 have no effect.
- R11: irq_o resets low, drops on an acknowledge read, and otherwise holds until R5 or R9 sets it.
- R12: A request in the same cycle as an acknowledge or end-of-interrupt is judged against the state before that cycle. If it sets irq_o, that wins over the drop from the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Delivery request strobe |
| req_src | input | SW | Source index of the request |
| req_prio | input | PW | Source priority |
| req_vec | input | VW | Source vector |
| src_active | input | NSRC | Current activity flag of each source |
| src_level | input | NSRC | 1 = level-sensitive, 0 = edge-sensitive |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, valid while rd_en is high |
| irq_o | output | 1 | Interrupt line to the processor |
| clr_valid | output | 1 | Pulse: clear the activity flag of clr_src |
| clr_src | output | SW | Source whose activity flag is to be cleared |

## Verification
A delivery request can land in the same clock as an acknowledge read or an end-of-interrupt write. The effect on irq_o then depends on which state each decision uses. The bench provokes this in two ways. It issues a directed request together with an acknowledge while a lower-priority entry is raised. It also runs a long random phase that draws requests, acknowledges, end-of-interrupt writes and task-priority writes independently. A behavioural model updates its arrays from the pre-edge state, as R12 requires. On every clock the bench compares the model against irq_o, rdata and the clear pulse.

// File: rtl/irq_presenter.sv
module irq_presenter #(
  parameter int NSRC   = 16,
  parameter int PW     = 4,
  parameter int VW     = 8,
  parameter int DW     = 32,
  parameter int CPU_ID = 0,
  localparam int SW    = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [SW-1:0]   req_src,
  input  logic [PW-1:0]   req_prio,
  input  logic [VW-1:0]   req_vec,
  input  logic [NSRC-1:0] src_active,
  input  logic [NSRC-1:0] src_level,
  input  logic            rd_en,
  input  logic            wr_en,
  input  logic [2:0]      addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  output logic            irq_o,
  output logic            clr_valid,
  output logic [SW-1:0]   clr_src
);
  localparam logic [2:0] A_TPRI = 3'd0;
  localparam logic [2:0] A_SPUR = 3'd1;
  localparam logic [2:0] A_WHO  = 3'd2;
  localparam logic [2:0] A_ACK  = 3'd3;
  localparam logic [2:0] A_EOI  = 3'd4;

  logic [NSRC-1:0] raised, insvc;
  logic [PW-1:0]   rprio [NSRC];
  logic [VW-1:0]   rvec  [NSRC];
  logic [PW-1:0]   sprio [NSRC];
  logic [PW-1:0]   tprio;
  logic [VW-1:0]   spur;
  logic            irq_q;

  // most urgent raised, most urgent in service, runner-up in service
  logic          r_hit, s_hit, s2_hit;
  logic [SW-1:0] r_idx, s_idx, s2_idx;
  logic [PW-1:0] r_best, s_best, s2_best;

  always_comb begin
    r_hit = 1'b0; r_idx = '0; r_best = '0;
    for (int i = 0; i < NSRC; i++)
      if (raised[i] && (!r_hit || rprio[i] > r_best)) begin
        r_hit = 1'b1; r_idx = SW'(i); r_best = rprio[i];
      end
  end

  always_comb begin
    s_hit = 1'b0; s_idx = '0; s_best = '0;
    for (int i = 0; i < NSRC; i++)
      if (insvc[i] && (!s_hit || sprio[i] > s_best)) begin
        s_hit = 1'b1; s_idx = SW'(i); s_best = sprio[i];
      end
  end

  always_comb begin
    s2_hit = 1'b0; s2_idx = '0; s2_best = '0;
    for (int i = 0; i < NSRC; i++)
      if (insvc[i] && SW'(i) != s_idx && (!s2_hit || sprio[i] > s2_best)) begin
        s2_hit = 1'b1; s2_idx = SW'(i); s2_best = sprio[i];
      end
  end

  wire ack     = rd_en && addr == A_ACK;
  wire eoi     = wr_en && addr == A_EOI;
  wire ack_ok  = r_hit && src_active[r_idx] && rprio[r_idx] > tprio;
  wire accept  = req_valid && req_prio > tprio && !raised[req_src];
  wire new_top = accept && (!r_hit || req_prio > r_best);
  wire eoi_up  = eoi && r_hit && (!s2_hit || r_best > s2_best);

  wire [NSRC-1:0] r_oh   = NSRC'(1) << r_idx;
  wire [NSRC-1:0] s_oh   = NSRC'(1) << s_idx;
  wire [NSRC-1:0] req_oh = NSRC'(1) << req_src;

  wire [NSRC-1:0] raised_clr = (ack && r_hit) ? r_oh : '0;
  wire [NSRC-1:0] raised_set = accept ? req_oh : '0;
  wire [NSRC-1:0] svc_set    = (ack && ack_ok) ? r_oh : '0;
  wire [NSRC-1:0] svc_clr    = (eoi && s_hit) ? s_oh : '0;

  assign clr_valid = ack && r_hit && (!ack_ok || !src_level[r_idx]);
  assign clr_src   = r_idx;
  assign irq_o     = irq_q;

  always_comb begin
    rdata = '0;
    if (rd_en)
      case (addr)
        A_TPRI:  rdata = DW'(tprio);
        A_SPUR:  rdata = DW'(spur);
        A_WHO:   rdata = DW'(CPU_ID);
        A_ACK:   rdata = ack_ok ? DW'(rvec[r_idx]) : DW'(spur);
        default: rdata = '0;
      endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raised <= '0;
      insvc  <= '0;
      tprio  <= '1;
      spur   <= '1;
      irq_q  <= 1'b0;
    end else begin
      raised <= (raised & ~raised_clr) | raised_set;
      insvc  <= (insvc & ~svc_clr) | svc_set;
      if (wr_en && addr == A_TPRI) tprio <= wdata[PW-1:0];
      if (wr_en && addr == A_SPUR) spur  <= wdata[VW-1:0];
      if (new_top || eoi_up) irq_q <= 1'b1;
      else if (ack)          irq_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      rprio[req_src] <= req_prio;
      rvec[req_src]  <= req_vec;
    end
    if (ack && ack_ok) sprio[r_idx] <= rprio[r_idx];
  end
endmodule

// File: rtl/irq_presenter_chk.sv
module irq_presenter_chk #(
  parameter int NSRC   = 16,
  parameter int PW     = 4,
  parameter int DW     = 32,
  parameter int CPU_ID = 0,
  localparam int SW    = $clog2(NSRC)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [PW-1:0] req_prio,
  input logic          rd_en,
  input logic          wr_en,
  input logic [2:0]    addr,
  input logic [DW-1:0] rdata,
  input logic          irq_o,
  input logic          clr_valid,
  input logic [PW-1:0] tprio
);
  wire ack = rd_en && addr == 3'd3;
  wire eoi = wr_en && addr == 3'd4;

  p_ack_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ack && !req_valid |=> !irq_o);

  p_irq_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid && !ack && !eoi |=> $stable(irq_o));

  p_low_prio_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_prio <= tprio && !rd_en && !wr_en |=> $stable(irq_o));

  p_clear_on_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_valid |-> ack);

  p_eoi_reads_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && addr == 3'd4 |-> rdata == '0);

  p_identity_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && addr == 3'd2 |-> rdata == DW'(CPU_ID));
endmodule

bind irq_presenter irq_presenter_chk #(
  .NSRC(NSRC), .PW(PW), .DW(DW), .CPU_ID(CPU_ID)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_prio(req_prio),
  .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .rdata(rdata),
  .irq_o(irq_o), .clr_valid(clr_valid), .tprio(tprio)
);

// File: tb/sim_irq_presenter.sv
module sim_irq_presenter;
  localparam int CLK_P = 10;
  localparam int N     = 16;
  localparam int ME    = 5;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0;
  logic [3:0] req_src = 0, req_prio = 0;
  logic [7:0] req_vec = 0;
  logic [N-1:0] src_active = '1, src_level = '0;
  logic rd_en = 0, wr_en = 0;
  logic [2:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic irq_o, clr_valid;
  logic [3:0] clr_src;

  always #(CLK_P/2) clk = ~clk;

  irq_presenter #(.NSRC(N), .CPU_ID(ME)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_src(req_src),
    .req_prio(req_prio), .req_vec(req_vec), .src_active(src_active),
    .src_level(src_level), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_o(irq_o), .clr_valid(clr_valid),
    .clr_src(clr_src));

  int errors = 0, checks = 0;
  bit done = 0;

  bit m_raised[N], m_svc[N];
  int m_rprio[N], m_rvec[N], m_sprio[N];
  int m_tprio = 15, m_spur = 255;
  bit m_irq = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int pick_r();
    int b = -1, k = -1;
    for (int i = 0; i < N; i++) if (m_raised[i] && m_rprio[i] > b) begin b = m_rprio[i]; k = i; end
    return k;
  endfunction

  function automatic int pick_s(int skip);
    int b = -1, k = -1;
    for (int i = 0; i < N; i++) if (m_svc[i] && i != skip && m_sprio[i] > b) begin b = m_sprio[i]; k = i; end
    return k;
  endfunction

  task automatic step();
    int rk, sk, s2, exp_rd;
    bit ack, eoi, ok, acc, up;
    #1;
    rk  = pick_r();
    sk  = pick_s(-1);
    s2  = pick_s(sk);
    ack = rd_en && addr == 3;
    eoi = wr_en && addr == 4;
    ok  = rk >= 0 && src_active[rk] && m_rprio[rk] > m_tprio;
    if (rd_en) begin
      case (addr)
        0: begin exp_rd = m_tprio; chk("R1 task priority read", rdata, exp_rd); end
        1: begin exp_rd = m_spur;  chk("R6 spurious read", rdata, exp_rd); end
        2: begin exp_rd = ME;      chk("R10 identity read", rdata, exp_rd); end
        3: begin exp_rd = ok ? m_rvec[rk] : m_spur; chk("R4 R6 R7 acknowledge vector", rdata, exp_rd); end
        default: chk("R10 eoi/unmapped read", rdata, 0);
      endcase
    end
    chk("R7 R8 clear pulse", clr_valid, int'(ack && rk >= 0 && (!ok || !src_level[rk])));
    if (ack && rk >= 0) chk("R7 R8 clear index", clr_src, rk);
    @(posedge clk);
    acc = req_valid && req_prio > m_tprio && !m_raised[req_src];
    up  = acc && (rk < 0 || req_prio > m_rprio[rk]);
    if (ack && rk >= 0) begin
      if (ok) begin m_svc[rk] = 1; m_sprio[rk] = m_rprio[rk]; end
      m_raised[rk] = 0;
    end
    if (eoi) begin
      if (rk >= 0 && (s2 < 0 || m_rprio[rk] > m_sprio[s2])) up = 1;
      if (sk >= 0) m_svc[sk] = 0;
    end
    if (acc) begin m_raised[req_src] = 1; m_rprio[req_src] = req_prio; m_rvec[req_src] = req_vec; end
    if (wr_en && addr == 0) m_tprio = wdata & 15;
    if (wr_en && addr == 1) m_spur = wdata & 255;
    if (up) m_irq = 1; else if (ack) m_irq = 0;
    @(negedge clk);
    chk("R5 R9 R11 R12 irq line", irq_o, m_irq);
  endtask

  task automatic op(bit rv, int s, int p, int v, bit rd, bit wr, int a, int d);
    req_valid = rv; req_src = 4'(s); req_prio = 4'(p); req_vec = 8'(v);
    rd_en = rd; wr_en = wr; addr = 3'(a); wdata = d;
    step();
    req_valid = 0; rd_en = 0; wr_en = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired (all requirements) actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R11 reset irq low", irq_o, 0);
    op(0,0,0,0, 1,0, 0,0);          // R1 reset value 15
    op(0,0,0,0, 1,0, 1,0);          // R6 reset 0xFF
    op(0,0,0,0, 1,0, 2,0);          // R10 identity
    op(0,0,0,0, 1,0, 3,0);          // R6 empty acknowledge
    op(0,0,0,0, 0,1, 0,32'h23);     // R1 only low bits kept -> 3
    op(0,0,0,0, 1,0, 0,0);
    op(1,5,3,8'h51, 0,0, 0,0);      // R2 prio 3 not above 3
    op(1,5,4,8'h55, 0,0, 0,0);      // R2 R5 accepted, irq up
    op(1,5,9,8'h59, 0,0, 0,0);      // R3 duplicate dropped
    op(1,2,4,8'h22, 0,0, 0,0);      // equal priority, lower index
    op(0,0,0,0, 1,0, 3,0);          // R4 expect 0x22, R8 edge clear, R11 drop
    op(0,0,0,0, 1,0, 3,0);          // R3 expect 0x55
    op(1,9,7,8'h99, 0,0, 0,0);      // R5
    op(1,1,6,8'h11, 0,0, 0,0);
    op(0,0,0,0, 0,1, 0,7);
    op(0,0,0,0, 1,0, 3,0);          // R7 priority 7 no longer above 7
    op(0,0,0,0, 0,1, 0,3);
    src_active[1] = 0; src_level[1] = 1;
    op(0,0,0,0, 1,0, 3,0);          // R7 inactive level source
    src_active[1] = 1; src_level[1] = 0;
    op(0,0,0,0, 0,1, 4,0);          // R9 retire src2 (tie, lowest index)
    op(0,0,0,0, 1,0, 4,0);          // R10 eoi reads zero
    op(0,0,0,0, 0,1, 2,32'h7);      // R10 identity write ignored
    op(0,0,0,0, 1,0, 2,0);
    op(0,0,0,0, 0,1, 3,32'h3);      // R10 acknowledge write ignored
    op(0,0,0,0, 0,1, 1,32'h1C7);    // R6 spurious write keeps 0xC7
    op(0,0,0,0, 1,0, 3,0);          // R6 empty -> 0xC7
    op(1,4,6,8'h44, 0,0, 0,0);
    op(1,3,8,8'h33, 1,0, 3,0);      // R12 request with acknowledge: irq stays up
    op(0,0,0,0, 1,0, 3,0);          // takes src3
    op(1,6,5,8'h66, 0,0, 0,0);
    op(1,7,5,8'h77, 0,0, 0,0);
    op(0,0,0,0, 1,0, 3,0);          // takes src6, irq low, src7 waits
    op(0,0,0,0, 0,1, 4,0);          // R9 retire 3, best left 6 -> stays low
    op(0,0,0,0, 0,1, 4,0);          // retire 4, best left 5 -> stays low
    op(0,0,0,0, 0,1, 4,0);          // retire 6, best left 4 -> R9 re-raise
    for (int n = 0; n < 3000; n++) begin
      int k = $urandom % 10;
      src_active = N'($urandom) | N'($urandom);
      src_level  = N'($urandom);
      op($urandom % 2, $urandom % N, $urandom % 16, $urandom % 256,
         k < 2, k >= 2 && k < 5,
         k < 2 ? 3 : (k < 4 ? 4 : (k == 4 ? 0 : 3)),
         ($urandom % 8) | (($urandom % 2) << 8));
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule